// File: doc/BRIEF.md
# Two-State Snooping Cache Node

This block is a direct-mapped, write-back cache controller for one processor that shares a snooping bus with other caches. Each line carries a tag and a single presence bit. No dirty bit exists, so a present line is either in use or absent. The processor issues word reads and writes through a valid/ready request channel. The controller accepts a request only when it is idle. Holding `cpu_req_ready` low is the only back-pressure it applies. The processor must keep the request stable while valid is high and ready is low. Each accepted request produces exactly one single-cycle response pulse. That pulse cannot be stalled.

Toward the bus, the controller raises a request that carries an operation and a line address. The bus fabric grants it for one cycle. Fetches complete later, when line data arrives on a fill strobe. The controller also watches every transaction that other nodes place on the bus. When it holds the requested line, it answers from its own copy and tells memory to keep quiet. Writes use a write-invalidate scheme. A write hit broadcasts an upgrade that carries no data and gets no reply. A write miss fetches the line with exclusive intent. A present line that must make room for a different tag is always written back before the new line is fetched.

Top module: `vi_snoop_cache`

## Requirements
- R1: After reset every line is absent, `cpu_req_ready` is 1, and `bus_req`, `cpu_rsp_valid` and `snp_supplied` are 0.
- R2: A read of a word whose line is present raises no bus request and returns the stored word.
- R3: A read miss issues `bus_op` 1 (read) for line address {tag,index}. The word address is {tag,index,offset}, with the offset in the low bits. The filled line becomes present, and the response carries the requested word of the fill.
- R4: A write miss issues `bus_op` 2 (read-exclusive). The written word is merged into the filled line, and the line becomes present.
- R5: A write hit issues `bus_op` 3 (upgrade) and waits for no fill. The word is written on the grant cycle, and the line stays present.
- R6: On a miss whose index holds a present line with another tag, `bus_op` 4 (write-back) is issued first, with that line's address and data on `bus_wdata`. The fetch follows it.
- R7: A snooped read (op 1) that hits a present line asserts `snp_supplied` and drives the line on `snp_data` in the same cycle. The line stays present.
- R8: A snooped read-exclusive (op 2) that hits asserts `snp_supplied`, drives the line, and then makes the line absent.
- R9: A snooped upgrade (op 3) that hits makes the line absent and never asserts `snp_supplied`.
- R10: A snoop that misses, or that carries op 0 or op 4, changes no line and never asserts `snp_supplied`.
- R11: Snoops take priority. `bus_req` is 0 in any cycle with `snp_valid`, and a pending request is re-decided from the line state the snoop leaves behind.
- R12: `cpu_req_ready` is high only while idle, and no bus request is raised then. Each accepted request yields one response pulse, never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller idle, request accepted on this edge |
| cpu_req_write | input | 1 | 1 for write, 0 for read |
| cpu_req_addr | input | ADDR_W | Word address {tag,index,offset} |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read word, or the written word for writes |
| bus_req | output | 1 | Controller wants the bus |
| bus_gnt | input | 1 | Grant; the transaction is issued in this cycle |
| bus_op | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W-log2(WORDS) | Line address {tag,index} |
| bus_wdata | output | DATA_W*WORDS | Line data for write-back |
| bus_fill_valid | input | 1 | Fill data for the outstanding fetch |
| bus_fill_data | input | DATA_W*WORDS | Fill line |
| snp_valid | input | 1 | Another node's transaction is on the bus |
| snp_op | input | 3 | Snooped operation, same coding as bus_op |
| snp_addr | input | ADDR_W-log2(WORDS) | Snooped line address |
| snp_supplied | output | 1 | This cache answers; memory must stay silent |
| snp_data | output | DATA_W*WORDS | Line data supplied in reply |

## Verification
The bench targets a write hit that is waiting for its grant while a snooped upgrade removes the line. A controller that kept its stale decision would broadcast an upgrade on data it no longer holds, where read-exclusive is the correct request. Conflict misses on a present line must show a write-back carrying that line's exact data before the fetch. Skipping or reordering that step loses writes that were never written through. Snoops are sent to present and absent lines, including write-back and idle opcodes. A wrong decode would either supply stale data or drop a line that should have stayed, and a later read would then show an unexpected bus fetch or a wrong word.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_RD   = 3'd1,
    OP_RDX  = 3'd2,
    OP_UPG  = 3'd3,
    OP_WB   = 3'd4
  } bus_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ACT  = 2'd1,
    SQ_FILL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vic_tag_store.sv
module vic_tag_store #(
  parameter int LINES = 4,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_vld,
  output logic [TAG_W-1:0] a_tag,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_vld,
  output logic [TAG_W-1:0] b_tag,
  input  logic             kill_en,
  input  logic [IDX_W-1:0] kill_idx,
  input  logic             drop_en,
  input  logic [IDX_W-1:0] drop_idx,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);
  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
      end else if (kill_en && kill_idx == IDX_W'(i)) begin
        vld_q[i] <= 1'b0;
      end else if (drop_en && drop_idx == IDX_W'(i)) begin
        vld_q[i] <= 1'b0;
      end else if (set_en && set_idx == IDX_W'(i)) begin
        vld_q[i] <= 1'b1;
        tag_q[i] <= set_tag;
      end
    end
  end

  assign a_vld = vld_q[a_idx];
  assign a_tag = tag_q[a_idx];
  assign b_vld = vld_q[b_idx];
  assign b_tag = tag_q[b_idx];
endmodule

// File: rtl/vic_line_store.sv
module vic_line_store #(
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  a_idx,
  output logic [LINE_W-1:0] a_line,
  input  logic [IDX_W-1:0]  b_idx,
  output logic [LINE_W-1:0] b_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_base,
  input  logic              merge_en,
  input  logic [OFF_W-1:0]  merge_off,
  input  logic [DATA_W-1:0] merge_word
);
  logic [LINE_W-1:0] mem_q [LINES];
  logic [LINE_W-1:0] new_line;

  always_comb begin
    new_line = wr_base;
    if (merge_en) new_line[merge_off*DATA_W +: DATA_W] = merge_word;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(i)) mem_q[i] <= new_line;
    end
  end

  assign a_line = mem_q[a_idx];
  assign b_line = mem_q[b_idx];
endmodule

// File: rtl/vic_seq.sv
module vic_seq
  import vic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  input  logic              snp_busy,
  input  logic              bus_gnt,
  input  logic              fill_valid,
  input  logic              lk_vld,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [IDX_W-1:0]  req_idx,
  output logic [TAG_W-1:0]  req_tag,
  output logic [OFF_W-1:0]  req_off,
  output logic [DATA_W-1:0] req_wdata,
  output logic              req_write,
  output logic              bus_req,
  output bus_op_e           bus_op,
  output logic              evict_now,
  output logic              upg_now,
  output logic              fill_now,
  output logic              done
);
  seq_state_e state_q;
  logic       hit;
  logic       granted;

  always_comb begin
    hit    = lk_vld && (lk_tag == req_tag);
    bus_op = OP_NONE;
    if (state_q == SQ_ACT) begin
      if (hit)         bus_op = req_write ? OP_UPG : OP_NONE;
      else if (lk_vld) bus_op = OP_WB;
      else             bus_op = req_write ? OP_RDX : OP_RD;
    end
  end

  assign bus_req       = (state_q == SQ_ACT) && (bus_op != OP_NONE) && !snp_busy;
  assign granted       = bus_req && bus_gnt;
  assign evict_now     = granted && (bus_op == OP_WB);
  assign upg_now       = granted && (bus_op == OP_UPG);
  assign fill_now      = (state_q == SQ_FILL) && fill_valid;
  assign done          = upg_now || fill_now ||
                         ((state_q == SQ_ACT) && !snp_busy && hit && !req_write);
  assign cpu_req_ready = (state_q == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      req_idx   <= '0;
      req_tag   <= '0;
      req_off   <= '0;
      req_wdata <= '0;
      req_write <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (cpu_req_valid) begin
          state_q   <= SQ_ACT;
          req_off   <= cpu_req_addr[OFF_W-1:0];
          req_idx   <= cpu_req_addr[OFF_W +: IDX_W];
          req_tag   <= cpu_req_addr[ADDR_W-1 -: TAG_W];
          req_wdata <= cpu_req_wdata;
          req_write <= cpu_req_write;
        end
        SQ_ACT: begin
          if (done) state_q <= SQ_IDLE;
          else if (granted && (bus_op == OP_RD || bus_op == OP_RDX)) state_q <= SQ_FILL;
        end
        SQ_FILL: if (fill_now) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vi_snoop_cache.sv
module vi_snoop_cache
  import vic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int WORDS  = 4,
  parameter int LINES  = 4,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int LINE_W  = DATA_W * WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  output logic               cpu_req_ready,
  input  logic               cpu_req_write,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic [DATA_W-1:0]  cpu_req_wdata,
  output logic               cpu_rsp_valid,
  output logic [DATA_W-1:0]  cpu_rsp_rdata,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic [2:0]         bus_op,
  output logic [LADDR_W-1:0] bus_addr,
  output logic [LINE_W-1:0]  bus_wdata,
  input  logic               bus_fill_valid,
  input  logic [LINE_W-1:0]  bus_fill_data,
  input  logic               snp_valid,
  input  logic [2:0]         snp_op,
  input  logic [LADDR_W-1:0] snp_addr,
  output logic               snp_supplied,
  output logic [LINE_W-1:0]  snp_data
);
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  logic [DATA_W-1:0] req_wdata;
  logic              req_write;
  logic              lk_vld, s_vld;
  logic [TAG_W-1:0]  lk_tag, s_tag;
  logic [LINE_W-1:0] lk_line, s_line;
  logic              evict_now, upg_now, fill_now, done;
  bus_op_e           seq_op;
  logic [IDX_W-1:0]  s_idx;
  logic [TAG_W-1:0]  s_want;
  logic              s_hit, s_kill;
  logic [DATA_W-1:0] done_word;

  assign s_idx  = snp_addr[IDX_W-1:0];
  assign s_want = snp_addr[LADDR_W-1 -: TAG_W];
  assign s_hit  = snp_valid && s_vld && (s_tag == s_want);
  assign snp_supplied = s_hit && (snp_op == OP_RD || snp_op == OP_RDX);
  assign s_kill       = s_hit && (snp_op == OP_RDX || snp_op == OP_UPG);
  assign snp_data     = snp_supplied ? s_line : '0;

  vic_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_seq (
    .clk, .rst_n, .cpu_req_valid, .cpu_req_ready, .cpu_req_write, .cpu_req_addr,
    .cpu_req_wdata, .snp_busy(snp_valid), .bus_gnt, .fill_valid(bus_fill_valid),
    .lk_vld, .lk_tag, .req_idx, .req_tag, .req_off, .req_wdata, .req_write,
    .bus_req, .bus_op(seq_op), .evict_now, .upg_now, .fill_now, .done
  );

  vic_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk, .rst_n, .a_idx(req_idx), .a_vld(lk_vld), .a_tag(lk_tag),
    .b_idx(s_idx), .b_vld(s_vld), .b_tag(s_tag),
    .kill_en(s_kill), .kill_idx(s_idx), .drop_en(evict_now), .drop_idx(req_idx),
    .set_en(fill_now), .set_idx(req_idx), .set_tag(req_tag)
  );

  vic_line_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_lines (
    .clk, .a_idx(req_idx), .a_line(lk_line), .b_idx(s_idx), .b_line(s_line),
    .wr_en(fill_now || upg_now), .wr_idx(req_idx),
    .wr_base(fill_now ? bus_fill_data : lk_line),
    .merge_en(req_write), .merge_off(req_off), .merge_word(req_wdata)
  );

  assign bus_op    = seq_op;
  assign bus_addr  = (seq_op == OP_WB) ? {lk_tag, req_idx} : {req_tag, req_idx};
  assign bus_wdata = lk_line;

  always_comb begin
    if (req_write)     done_word = req_wdata;
    else if (fill_now) done_word = bus_fill_data[req_off*DATA_W +: DATA_W];
    else               done_word = lk_line[req_off*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      cpu_rsp_valid <= done;
      if (done) cpu_rsp_rdata <= done_word;
    end
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req_ready,
  input logic       cpu_rsp_valid,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [2:0] bus_op,
  input logic       snp_valid,
  input logic [2:0] snp_op,
  input logic       snp_supplied
);
  // R11
  snoop_blocks_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !bus_req);

  // R12
  idle_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_ready |-> !bus_req);

  // R12
  single_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  // R9
  upgrade_never_supplied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op == 3'd3) |-> !snp_supplied);

  // R10
  supply_only_on_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supplied |-> (snp_valid && (snp_op == 3'd1 || snp_op == 3'd2)));

  // R6
  fetch_after_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_op == 3'd4) |=> (bus_op == 3'd1 || bus_op == 3'd2));
endmodule

bind vi_snoop_cache vic_checker u_vic_checker (
  .clk(clk), .rst_n(rst_n), .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_op(bus_op), .snp_valid(snp_valid),
  .snp_op(snp_op), .snp_supplied(snp_supplied)
);

// File: tb/vi_snoop_cache_bench.sv
module vi_snoop_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8, DATA_W = 16, WORDS = 4, LINES = 4;
  localparam int OFF_W = 2, IDX_W = 2, TAG_W = 4, LADDR_W = 6, LINE_W = 64;

  logic clk = 0, rst_n = 0;
  logic cpu_req_valid = 0, cpu_req_write = 0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [DATA_W-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid, bus_req, snp_supplied;
  logic [DATA_W-1:0] cpu_rsp_rdata;
  logic bus_gnt = 0, bus_fill_valid = 0, snp_valid = 0;
  logic [2:0] bus_op, snp_op = '0;
  logic [LADDR_W-1:0] bus_addr, snp_addr = '0;
  logic [LINE_W-1:0] bus_wdata, snp_data, bus_fill_data = '0;

  vi_snoop_cache u_vi_snoop_cache (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic              m_vld [LINES];
  logic [TAG_W-1:0]  m_tag [LINES];
  logic [LINE_W-1:0] m_data[LINES];
  logic [LINE_W-1:0] mem   [1<<LADDR_W];
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] merge(input logic [LINE_W-1:0] l,
      input logic [OFF_W-1:0] off, input logic [DATA_W-1:0] w);
    logic [LINE_W-1:0] r = l;
    r[off*DATA_W +: DATA_W] = w;
    return r;
  endfunction

  function automatic logic [2:0] exp_op(input bit wr, input logic [IDX_W-1:0] idx,
                                        input logic [TAG_W-1:0] tg);
    if (m_vld[idx] && m_tag[idx] == tg) return wr ? 3'd3 : 3'd0;
    if (m_vld[idx]) return 3'd4;
    return wr ? 3'd2 : 3'd1;
  endfunction

  function automatic string op_req(input logic [2:0] op);
    case (op)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic snoop(input logic [2:0] op, input logic [LADDR_W-1:0] la);
    logic [IDX_W-1:0] idx = la[IDX_W-1:0];
    logic [TAG_W-1:0] tg = la[LADDR_W-1 -: TAG_W];
    bit hit = m_vld[idx] && m_tag[idx] == tg;
    bit sup = hit && (op == 3'd1 || op == 3'd2);
    string rq = !hit ? "R10" : (op == 3'd1 ? "R7" : op == 3'd2 ? "R8" : op == 3'd3 ? "R9" : "R10");
    @(negedge clk);
    snp_valid = 1; snp_op = op; snp_addr = la;
    #1;
    chk(snp_supplied == sup, rq, "snp_supplied", LINE_W'(snp_supplied), LINE_W'(sup));
    if (sup) chk(snp_data == m_data[idx], rq, "snp_data", snp_data, m_data[idx]);
    if (hit && (op == 3'd2 || op == 3'd3)) m_vld[idx] = 0;
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic cpu_op(input bit wr, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] wd, input logic [2:0] inj);
    logic [IDX_W-1:0] idx = a[OFF_W +: IDX_W];
    logic [TAG_W-1:0] tg = a[ADDR_W-1 -: TAG_W];
    logic [OFF_W-1:0] off = a[OFF_W-1:0];
    bit hit0 = m_vld[idx] && m_tag[idx] == tg;
    string rq = !hit0 ? (wr ? "R4" : "R3") : (wr ? "R5" : "R2");
    bit done = 0, fill_pend = 0, injected = (inj == 3'd0);
    int fill_wait = 0;
    logic [2:0] eo;
    logic [DATA_W-1:0] ew;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    while (!cpu_req_ready) @(negedge clk);
    for (int cyc = 0; ; cyc++) begin
      @(negedge clk);
      cpu_req_valid = 0; bus_gnt = 0; bus_fill_valid = 0; snp_valid = 0;
      #1;
      if (cpu_rsp_valid) begin
        ew = wr ? wd : m_data[idx][off*DATA_W +: DATA_W];
        chk(done, "R12", "response before completion", LINE_W'(cpu_rsp_valid), LINE_W'(done));
        chk(cpu_rsp_rdata == ew, rq, "response word", LINE_W'(cpu_rsp_rdata), LINE_W'(ew));
        break;
      end
      if (cyc > 60) begin
        chk(0, rq, "no response", 0, 1);
        break;
      end
      if (fill_pend) begin
        fill_wait--;
        if (fill_wait == 0) begin
          bus_fill_valid = 1;
          bus_fill_data = mem[{tg, idx}];
          m_data[idx] = wr ? merge(mem[{tg, idx}], off, wd) : mem[{tg, idx}];
          m_vld[idx] = 1; m_tag[idx] = tg;
          done = 1; fill_pend = 0;
        end
      end else if (bus_req) begin
        if (!injected) begin
          injected = 1;
          snp_valid = 1; snp_op = inj; snp_addr = {tg, idx};
          #1;
          chk(!bus_req, "R11", "bus_req during snoop", LINE_W'(bus_req), 0);
          if (m_vld[idx] && m_tag[idx] == tg && (inj == 3'd2 || inj == 3'd3)) m_vld[idx] = 0;
        end else begin
          eo = exp_op(wr, idx, tg);
          chk(bus_op == eo, op_req(eo), "bus_op", LINE_W'(bus_op), LINE_W'(eo));
          if (eo == 3'd4) begin
            chk(bus_addr == {m_tag[idx], idx}, "R6", "victim address",
                LINE_W'(bus_addr), LINE_W'({m_tag[idx], idx}));
            chk(bus_wdata == m_data[idx], "R6", "victim data", bus_wdata, m_data[idx]);
          end else if (eo != 3'd0) begin
            chk(bus_addr == {tg, idx}, op_req(eo), "bus_addr",
                LINE_W'(bus_addr), LINE_W'({tg, idx}));
          end
          if (eo != 3'd0 && bus_op == eo && ($urandom % 3) != 0) begin
            bus_gnt = 1;
            if (eo == 3'd4) begin
              mem[{m_tag[idx], idx}] = m_data[idx];
              m_vld[idx] = 0;
            end else if (eo == 3'd3) begin
              m_data[idx] = merge(m_data[idx], off, wd);
              done = 1;
            end else begin
              fill_pend = 1;
              fill_wait = 1 + int'($urandom % 3);
            end
          end
        end
      end else if (!done && exp_op(wr, idx, tg) == 3'd0 && !wr) begin
        done = 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R12", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4177));
    for (int i = 0; i < (1 << LADDR_W); i++) mem[i] = {$urandom, $urandom};
    for (int i = 0; i < LINES; i++) begin
      m_vld[i] = 0; m_tag[i] = '0; m_data[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: idle outputs after reset
    chk(cpu_req_ready == 1, "R1", "ready", LINE_W'(cpu_req_ready), 1);
    chk(bus_req == 0, "R1", "bus_req", LINE_W'(bus_req), 0);
    chk(cpu_rsp_valid == 0, "R1", "rsp_valid", LINE_W'(cpu_rsp_valid), 0);
    // R1: every line absent, so snooped reads get no supply
    for (int i = 0; i < LINES; i++) snoop(3'd1, LADDR_W'(i));

    cpu_op(0, 8'h15, '0, 0);          // R3 read miss
    cpu_op(0, 8'h16, '0, 0);          // R2 read hit
    cpu_op(1, 8'h17, 16'hbeef, 0);    // R5 write hit upgrade
    cpu_op(0, 8'h17, '0, 0);          // R2 reads merged word
    cpu_op(0, 8'h25, '0, 0);          // R6 conflict: write-back then read
    cpu_op(1, 8'h3a, 16'h1234, 0);    // R4 write miss
    snoop(3'd1, 6'h0e);               // R7 supply, keep
    cpu_op(0, 8'h38, '0, 0);          // R7 still present: hit
    snoop(3'd2, 6'h0e);               // R8 supply, drop
    cpu_op(0, 8'h39, '0, 0);          // R8 absent: read miss
    snoop(3'd3, 6'h0e);               // R9 drop, no data
    snoop(3'd4, 6'h09);               // R10 write-back op ignored
    snoop(3'd0, 6'h09);               // R10 idle op ignored
    snoop(3'd3, 6'h19);               // R10 tag mismatch ignored
    cpu_op(0, 8'h25, '0, 0);          // R10 line still present
    cpu_op(1, 8'h26, 16'h5a5a, 3'd3); // R11 upgrade pending, snooped upgrade turns it into read-exclusive
    cpu_op(1, 8'h27, 16'h7777, 3'd1); // R11 snooped read delays upgrade

    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] a = {2'b00, 2'($urandom), 2'($urandom), 2'($urandom)};
      if ($urandom % 5 == 0) snoop(3'($urandom % 5), a[ADDR_W-1:OFF_W]);
      else cpu_op(1'($urandom), a, 16'($urandom), ($urandom % 8 == 0) ? 3'($urandom % 4) : 3'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule